// File: doc/BRIEF.md
# Dual-Context Configuration Memory Controller

This block keeps a programmable-logic configuration image in two copies. The first copy is volatile. It sits in flip-flops that are filled one bit at a time through a serial chain. The second copy models non-volatile latches, which reset does not clear. A commit command copies the volatile image into the latches. The copy goes one group at a time, because every group of latches shares a single write generator. Inside each group, the volatile bit decides whether its latch is heated during each write phase.

The configuration output is fed either by the flip-flops or straight from the latches, and a context-select command picks which one. Once a commit has finished, a new image can be shifted into the flip-flops while the latches keep driving the logic. This gives two configurations that can be swapped without a reload.

The heating currents and the write field are modelled as per-group enable pulses of a fixed length. Each group is written in two phases. In the set phase, a field of polarity 1 is applied and only latches whose volatile bit is 1 are heated. In the clear phase, a field of polarity 0 is applied and only latches whose volatile bit is 0 are heated.

Top module: `dualctx_cfg_mem`

## Requirements
- R1: After a synchronous active-low reset, the volatile image is all zeros, `ctx_nv` is 1 (the latches are selected), `busy` is 0, `sh_full` is 0 and `grp_wr_en` is 0.
- R2: While idle, each cycle with `sh_valid` high shifts `sh_bit` into the volatile image, most significant bit first: bit 0 takes the new bit and every other bit moves up by one. After N accepted bits, the first bit accepted sits at `cfg_out[N-1]` when the volatile context is selected.
- R3: `sh_full` is 1 exactly when N bits have been accepted since reset or since the last wrap. The next accepted bit restarts the count at 1, so `sh_full` falls.
- R4: A `commit_req` seen while idle raises `busy` from the next cycle. `busy` then stays high for NUM_GROUPS*2*WRITE_CYCLES cycles.
- R5: During a commit, `grp_wr_en` is one-hot and walks the groups in ascending order starting at group 0. Each group spends WRITE_CYCLES cycles with `wr_set_phase`=1, then WRITE_CYCLES cycles with `wr_set_phase`=0.
- R6: At the end of the set phase, the group's latches whose volatile bit is 1 become 1. At the end of the clear phase, those whose volatile bit is 0 become 0. After a commit the latch image therefore equals the volatile image, whatever the latches held before.
- R7: While `busy` is 1, `sh_valid` and `commit_req` are ignored.
- R8: A `sel_wr` strobe while idle sets `ctx_nv` to `sel_nv` on the next cycle. A strobe while busy is held and takes effect on the cycle after `busy` falls; the last strobe wins.
- R9: Reset does not change the latch image. After reset, `cfg_out` shows the image committed before reset.
- R10: Shifting a new image after a commit leaves the latch image and `cfg_out` unchanged while `ctx_nv` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sh_valid | input | 1 | Shift strobe, one bit per cycle |
| sh_bit | input | 1 | Serial configuration bit |
| sh_full | output | 1 | A full image has been shifted in |
| commit_req | input | 1 | Start copying the volatile image into the latches |
| sel_wr | input | 1 | Context-select strobe |
| sel_nv | input | 1 | Requested context: 1 latches, 0 flip-flops |
| busy | output | 1 | Commit in progress |
| grp_wr_en | output | NUM_GROUPS | Per-group write enable, one-hot while busy |
| wr_set_phase | output | 1 | 1 in the set phase of a group write |
| ctx_nv | output | 1 | Active context: 1 latches, 0 flip-flops |
| cfg_out | output | NUM_GROUPS*GROUP_W | Configuration output from the active context |

## Verification
The image is tried with three patterns. A sparse one-in-three pattern shows that bits land in the right order. Its complement, committed over it, shows that both phases take effect: a missing set or clear phase would leave stale bits. A pseudo-random pattern, with idle gaps in the shift stream, shows that the chain advances only on accepted bits. Shift, commit and select requests made in the middle of a commit tell the deferred select apart from the refused requests. A reset after a commit, followed by loading a new image while the latches are active, tells the retained latch image apart from the volatile one.

// File: rtl/cfg_pkg.sv
// Shared types for the dual-context configuration memory.
package cfg_pkg;
    // Write phase of one group: set heats bits whose volatile value is 1, clear heats the 0s.
    typedef enum logic {
        PH_SET = 1'b0,
        PH_CLR = 1'b1
    } wr_phase_e;
endpackage

// File: rtl/cfg_shift_chain.sv
// Volatile configuration image loaded MSB-first, one bit per accepted cycle.
// Assumes: hold is high for the whole of a commit; a count of N marks a full image.
module cfg_shift_chain #(
    parameter int N = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid,
    input  logic         din,
    input  logic         hold,
    output logic [N-1:0] vol,
    output logic         full
);
    localparam int CNTW = $clog2(N + 1);

    logic [N-1:0]    vol_q;
    logic [CNTW-1:0] cnt_q;
    logic            accept;

    assign accept = valid & ~hold;

    // Shift the image and count accepted bits, wrapping after a full image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_q <= '0;
            cnt_q <= '0;
        end else if (accept) begin
            vol_q <= {vol_q[N-2:0], din};
            cnt_q <= (cnt_q == CNTW'(N)) ? CNTW'(1) : cnt_q + CNTW'(1);
        end
    end

    assign vol  = vol_q;
    assign full = (cnt_q == CNTW'(N));

    // R7: the image is frozen during a commit.
    p_hold_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(vol_q));

    // R3: one more accepted bit after a full image restarts the count.
    p_full_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && accept) |=> !full);
endmodule

// File: rtl/cfg_commit_seq.sv
// Commit sequencer: walks groups in ascending order, each with a set then a clear phase
// of WRITE_CYCLES cycles. Only one group owns the shared write generator at a time.
// Assumes: start is ignored while a commit runs.
module cfg_commit_seq
    import cfg_pkg::*;
#(
    parameter int NUM_GROUPS   = 4,
    parameter int WRITE_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  busy,
    output logic [NUM_GROUPS-1:0] grp_oh,
    output logic                  set_phase,
    output logic                  upd,
    output logic                  done
);
    localparam int GIW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int CW  = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;

    logic           busy_q;
    logic [GIW-1:0] grp_q;
    logic [CW-1:0]  cnt_q;
    wr_phase_e      ph_q;
    logic           last_cyc;

    assign last_cyc = (cnt_q == CW'(WRITE_CYCLES - 1));

    // Advance the cycle counter, phase and group index through the commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            grp_q  <= '0;
            cnt_q  <= '0;
            ph_q   <= PH_SET;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                grp_q  <= '0;
                cnt_q  <= '0;
                ph_q   <= PH_SET;
            end
        end else if (last_cyc) begin
            cnt_q <= '0;
            if (ph_q == PH_SET) begin
                ph_q <= PH_CLR;
            end else begin
                ph_q <= PH_SET;
                if (grp_q == GIW'(NUM_GROUPS - 1)) busy_q <= 1'b0;
                else                               grp_q  <= grp_q + GIW'(1);
            end
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // Decode the active group into one enable per group.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_oh
        assign grp_oh[g] = busy_q && (grp_q == GIW'(g));
    end

    assign busy      = busy_q;
    assign set_phase = busy_q && (ph_q == PH_SET);
    assign upd       = busy_q && last_cyc;
    assign done      = upd && (ph_q == PH_CLR) && (grp_q == GIW'(NUM_GROUPS - 1));

    // R5: at most one group drives the shared generator.
    p_one_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_oh));

    // R5: group changes during a commit step up by exactly one.
    p_grp_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && grp_q != $past(grp_q)) |-> (grp_q == $past(grp_q) + GIW'(1)));
endmodule

// File: rtl/cfg_nv_bank.sv
// Modelled non-volatile latches. They have no reset, so their contents survive rst_n.
// A group is written at the end of each phase. Set heats the latches whose volatile
// bit is 1 and drives 1; clear heats those whose bit is 0 and drives 0.
// Assumes: upd lasts one cycle per phase and grp_oh is one-hot while upd is high.
module cfg_nv_bank #(
    parameter int NUM_GROUPS = 4,
    parameter int GROUP_W    = 64
) (
    input  logic                          clk,
    input  logic                          upd,
    input  logic                          set_phase,
    input  logic [NUM_GROUPS-1:0]         grp_oh,
    input  logic [NUM_GROUPS*GROUP_W-1:0] vol,
    output logic [NUM_GROUPS*GROUP_W-1:0] nv
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic [GROUP_W-1:0] lat_q;
        logic [GROUP_W-1:0] vg;

        assign vg = vol[g*GROUP_W +: GROUP_W];

        // Apply the heated-bit write of this group at the end of each phase.
        always_ff @(posedge clk) begin
            if (upd && grp_oh[g]) begin
                if (set_phase) lat_q <= lat_q | vg;
                else           lat_q <= lat_q & vg;
            end
        end

        assign nv[g*GROUP_W +: GROUP_W] = lat_q;
    end
endmodule

// File: rtl/dualctx_cfg_mem.sv
// Top level: the volatile shift chain, the latch bank and the commit sequencer, plus the
// context selector that picks which copy drives cfg_out. Select strobes that arrive during
// a commit are held and applied when the commit ends.
module dualctx_cfg_mem #(
    parameter int NUM_GROUPS   = 4,
    parameter int GROUP_W      = 64,
    parameter int WRITE_CYCLES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sh_valid,
    input  logic                          sh_bit,
    output logic                          sh_full,
    input  logic                          commit_req,
    input  logic                          sel_wr,
    input  logic                          sel_nv,
    output logic                          busy,
    output logic [NUM_GROUPS-1:0]         grp_wr_en,
    output logic                          wr_set_phase,
    output logic                          ctx_nv,
    output logic [NUM_GROUPS*GROUP_W-1:0] cfg_out
);
    localparam int N = NUM_GROUPS * GROUP_W;

    logic [N-1:0] vol;
    logic [N-1:0] nv;
    logic         upd;
    logic         done;
    logic         ctx_q;
    logic         pend_q;
    logic         pend_val_q;

    cfg_shift_chain #(.N(N)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (sh_valid),
        .din   (sh_bit),
        .hold  (busy),
        .vol   (vol),
        .full  (sh_full)
    );

    cfg_commit_seq #(.NUM_GROUPS(NUM_GROUPS), .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (commit_req),
        .busy      (busy),
        .grp_oh    (grp_wr_en),
        .set_phase (wr_set_phase),
        .upd       (upd),
        .done      (done)
    );

    cfg_nv_bank #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)) u_nv (
        .clk       (clk),
        .upd       (upd),
        .set_phase (wr_set_phase),
        .grp_oh    (grp_wr_en),
        .vol       (vol),
        .nv        (nv)
    );

    // Track the active context and hold select strobes that arrive during a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q      <= 1'b1;
            pend_q     <= 1'b0;
            pend_val_q <= 1'b1;
        end else if (!busy) begin
            if (sel_wr) ctx_q <= sel_nv;
        end else if (done) begin
            pend_q <= 1'b0;
            if (sel_wr)      ctx_q <= sel_nv;
            else if (pend_q) ctx_q <= pend_val_q;
        end else if (sel_wr) begin
            pend_q     <= 1'b1;
            pend_val_q <= sel_nv;
        end
    end

    assign ctx_nv  = ctx_q;
    assign cfg_out = ctx_q ? nv : vol;

    // R8: the active context cannot change between two busy cycles.
    p_ctx_defer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ctx_q));

    // R4: a commit ends with busy falling on the cycle after done.
    p_done_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: tb/tb_dualctx_cfg_mem.sv
// Bench: a behavioural reference model updated on every rising edge and compared with
// the outputs on every falling edge.
module tb_dualctx_cfg_mem;
    localparam int NG  = 4;
    localparam int GW  = 64;
    localparam int WC  = 4;
    localparam int N   = NG * GW;
    localparam int TOT = NG * 2 * WC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sh_valid = 1'b0, sh_bit = 1'b0, commit_req = 1'b0, sel_wr = 1'b0, sel_nv = 1'b0;
    logic sh_full, busy, wr_set_phase, ctx_nv;
    logic [NG-1:0] grp_wr_en;
    logic [N-1:0]  cfg_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dualctx_cfg_mem #(.NUM_GROUPS(NG), .GROUP_W(GW), .WRITE_CYCLES(WC)) dut (
        .clk(clk), .rst_n(rst_n), .sh_valid(sh_valid), .sh_bit(sh_bit), .sh_full(sh_full),
        .commit_req(commit_req), .sel_wr(sel_wr), .sel_nv(sel_nv), .busy(busy),
        .grp_wr_en(grp_wr_en), .wr_set_phase(wr_set_phase), .ctx_nv(ctx_nv), .cfg_out(cfg_out)
    );

    // Reference model state.
    logic [N-1:0] m_vol;
    logic [N-1:0] m_nv = 'x;
    bit m_nvk = 0;
    int m_cnt = 0, m_k = 0;
    bit m_busy = 0, m_ctx = 1, m_pend = 0, m_pv = 1;

    always @(posedge clk) begin
        bit ob;
        if (!rst_n) begin
            m_vol = '0; m_cnt = 0; m_busy = 0; m_ctx = 1; m_pend = 0; m_k = 0;
        end else begin
            ob = m_busy;
            if (ob) begin
                if (m_k % WC == WC - 1) begin
                    for (int i = (m_k / (2 * WC)) * GW; i < (m_k / (2 * WC) + 1) * GW; i++) begin
                        if ((m_k / WC) % 2 == 0) begin
                            if (m_vol[i]) m_nv[i] = 1'b1;
                        end else begin
                            if (!m_vol[i]) m_nv[i] = 1'b0;
                        end
                    end
                end
                if (sel_wr) begin m_pend = 1; m_pv = sel_nv; end
                if (m_k == TOT - 1) begin
                    m_busy = 0; m_nvk = 1;
                    if (m_pend) m_ctx = m_pv;
                    m_pend = 0;
                end else m_k++;
            end else begin
                if (sel_wr) m_ctx = sel_nv;
                if (commit_req) begin m_busy = 1; m_k = 0; end
            end
            if (!ob && sh_valid) begin
                m_vol = {m_vol[N-2:0], sh_bit};
                m_cnt = (m_cnt == N) ? 1 : m_cnt + 1;
            end
        end
    end

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare every output against the model.
    task automatic compare();
        logic [NG-1:0] eg;
        eg = m_busy ? NG'(1) << (m_k / (2 * WC)) : '0;
        chk("R4 R7 busy", N'(busy), N'(m_busy));
        chk("R5 grp_wr_en", N'(grp_wr_en), N'(eg));
        chk("R5 wr_set_phase", N'(wr_set_phase), N'(m_busy && ((m_k / WC) % 2 == 0)));
        chk("R8 ctx_nv", N'(ctx_nv), N'(m_ctx));
        chk("R3 sh_full", N'(sh_full), N'(m_cnt == N));
        if (!m_ctx || m_nvk) chk("R2 R6 cfg_out", cfg_out, m_ctx ? m_nv : m_vol);
    endtask

    task automatic step(bit v, bit b, bit c, bit sw, bit sv);
        sh_valid = v; sh_bit = b; commit_req = c; sel_wr = sw; sel_nv = sv;
        @(negedge clk);
        compare();
    endtask

    function automatic bit pat(int p, int j);
        case (p)
            0: return (j % 3 == 0);
            1: return !(j % 3 == 0);
            default: return 1'(((j * 37 + 11) ^ (j >> 2)) >> 3);
        endcase
    endfunction

    task automatic load(int p);
        for (int j = 0; j < N; j++) begin
            if (j % 37 == 5) step(0, 1, 0, 0, 0);
            step(1, pat(p, j), 0, 0, 0);
        end
        step(0, 0, 0, 0, 0);
    endtask

    task automatic commit_run(bit disturb);
        step(0, 0, 1, 0, 0);
        for (int t = 0; t < TOT; t++) begin
            if (disturb && t == 3)      step(1, 1, 1, 1, 1); // R7/R8: refused shift and commit, held select
            else if (disturb && t == 9) step(0, 0, 1, 1, 0); // R8: last held select wins
            else                        step(0, 0, 0, 0, 0);
        end
        step(0, 0, 0, 0, 0);
    endtask

    initial begin
        logic [N-1:0] img;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        chk("R1 ctx_nv", N'(ctx_nv), N'(1));
        chk("R1 busy", N'(busy), '0);
        chk("R1 sh_full", N'(sh_full), '0);
        chk("R1 grp_wr_en", N'(grp_wr_en), '0);
        step(0, 0, 0, 1, 0);
        chk("R1 volatile zero", cfg_out, '0);
        load(0);
        chk("R2 first bit at MSB", N'(cfg_out[N-1]), N'(pat(0, 0)));
        chk("R3 full after N", N'(sh_full), N'(1));
        commit_run(1);
        step(0, 0, 0, 1, 1);
        img = cfg_out;
        chk("R6 latch image A", img, m_vol);
        load(1);                          // R10: new image while latches are active
        chk("R10 latches undisturbed", cfg_out, img);
        step(1, 1, 0, 0, 0);
        chk("R3 wrap drops full", N'(sh_full), '0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0);
        load(1);
        commit_run(0);                    // R6: complement written over A
        step(0, 0, 0, 1, 1);
        chk("R6 latch image B", cfg_out, m_vol);
        img = cfg_out;
        load(2);
        commit_run(1);
        step(0, 0, 0, 1, 1);
        img = cfg_out;
        chk("R6 latch image C", img, m_vol);
        rst_n = 1'b0;
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0);
        chk("R9 latches kept over reset", cfg_out, img);
        chk("R1 ctx after reset", N'(ctx_nv), N'(1));
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule